// File: doc/BRIEF.md
# Configurable Character Serializer with Parity

This block turns parallel characters into a bit stream on a single data line. A character is 1 to 8 bits wide. It can carry one parity bit, which is sent after its data bits. The parity bit can be even, odd, forced low or forced high. Bits leave least significant first. Each bit is held for one interval of an external bit-rate strobe. When nothing is being sent, the line rests at logic 1. Framing bits, line coding and checksums are handled elsewhere.

Characters enter through a one-entry holding register with a ready/load handshake, so a second character can wait while the first is shifting. A two-bit enable field picks one of four behaviours:
- halt at once, discarding work in flight;
- drain, where the current character finishes and nothing new begins;
- run freely;
- run only while a clear-to-send input is high, where a character already under way always completes.

Length and parity settings are sampled at the strobe on which each character begins.

Top module: `ctx_serializer`

## Requirements
- R1: After reset, `txd` is 1, `tx_idle` is 1 and `tx_ready` is 1 (with `en_mode` not 00).
- R2: `len_sel` code 000 sends 8 data bits, and codes 001 to 111 send 1 to 7 data bits. Data goes out least significant bit first.
- R3: With `par_en` = 1, exactly one parity bit follows the last data bit. With `par_en` = 0, no bit follows the data.
- R4: `par_sel` 00 gives even parity (data plus parity holds an even count of ones). 01 gives odd parity, 10 forces the bit to 0 and 11 forces it to 1.
- R5: Outside a halt, `txd` changes only on a clock edge where `bit_tick` is 1, so each bit lasts one strobe interval.
- R6: In run mode (`en_mode` 10), a character waiting in the holding register starts on the strobe that ends the previous character, with no idle interval between them.
- R7: In clear-to-send mode (`en_mode` 11), a character starts only while `cts` is 1. If `cts` falls mid-character, that character still completes.
- R8: In drain mode (`en_mode` 01), the character being shifted completes and no further character starts. A waiting character stays held and is sent once the mode returns to run.
- R9: In halt mode (`en_mode` 00), one clock later `txd` is 1 and `tx_idle` is 1, the shifting character and the waiting character are discarded, and `tx_ready` is 0.
- R10: Whenever `tx_idle` is 1, `txd` is 1.
- R11: `tx_ready` is 1 exactly when the holding register is empty and the mode is not halt. A `tx_load` while `tx_ready` is 0 is ignored, and a held character is never overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 8 | Character to send; bit 0 goes first |
| tx_load | input | 1 | Offers `tx_data`; taken when `tx_ready` is 1 |
| tx_ready | output | 1 | Holding register can take a character |
| len_sel | input | 3 | Data bit count; 000 means eight |
| par_en | input | 1 | Append a parity bit |
| par_sel | input | 2 | Parity kind: 00 even, 01 odd, 10 zero, 11 one |
| en_mode | input | 2 | 00 halt, 01 drain, 10 run, 11 clear-to-send gated |
| cts | input | 1 | Clear-to-send, used in mode 11 |
| bit_tick | input | 1 | One-cycle strobe marking each bit boundary |
| txd | output | 1 | Serial data, 1 when idle |
| tx_idle | output | 1 | No character is being shifted |

## Verification
The assertions take for granted that `cts`, `en_mode` and `bit_tick` are already synchronous to `clk`. They also assume `bit_tick` never stays high for two cycles in a row. The stimulus drives every input on the falling edge and pulses the strobe for one cycle in every four. It changes length and parity settings only while the line is idle and nothing waits in the holding register, so each character's expected bits follow from the settings in force when it was loaded. Halt is entered only from the falling edge, and the expected-bit queue is emptied right after it.

// File: rtl/ctx_pkg.sv
// Shared encodings for the character serializer.
// Assumes: field codes match the programming values listed in the brief.
package ctx_pkg;
    typedef enum logic [1:0] {
        PAR_EVEN  = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_SPACE = 2'b10,
        PAR_MARK  = 2'b11
    } par_kind_e;

    typedef enum logic [1:0] {
        EN_HALT  = 2'b00,
        EN_DRAIN = 2'b01,
        EN_RUN   = 2'b10,
        EN_CTS   = 2'b11
    } en_mode_e;
endpackage

// File: rtl/ctx_holdbuf.sv
// One-entry holding register between the parallel side and the shifter.
// Assumes: load and take are never high together (load needs empty, take needs full).
module ctx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              take,
    input  logic              flush,
    output logic              valid,
    output logic [DATA_W-1:0] q
);
    // Capture, hand over or discard the waiting character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (take) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            q     <= data;
        end
    end

    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !take && !flush) |=> (valid && $stable(q)));
    assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);
endmodule

// File: rtl/ctx_framer.sv
// Builds the bit frame for one character: data bits LSB first, then parity.
// Assumes: DATA_W equals 2**LEN_W so that code zero stands for the full width.
module ctx_framer
    import ctx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 3,
    parameter int FRAME_W = DATA_W + 1,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [LEN_W-1:0]   len_code,
    input  logic               par_en,
    input  par_kind_e          par_kind,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   frame_len
);
    logic [CNT_W-1:0]  nbits;
    logic [DATA_W-1:0] masked;
    logic              par_bit;

    // Decode the length code; zero means the full data width.
    always_comb begin
        if (len_code == '0) nbits = CNT_W'(DATA_W);
        else                nbits = CNT_W'(len_code);
    end

    // Keep only the bits that will be sent, for parity.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = data[i] & (i < int'(nbits));
        end
    end

    // Pick the parity bit for the selected kind.
    always_comb begin
        unique case (par_kind)
            PAR_EVEN:  par_bit = ^masked;
            PAR_ODD:   par_bit = ~(^masked);
            PAR_SPACE: par_bit = 1'b0;
            PAR_MARK:  par_bit = 1'b1;
            default:   par_bit = 1'b1;
        endcase
    end

    // Lay out the frame; unused positions rest at mark.
    always_comb begin
        frame = '1;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nbits)) frame[i] = data[i];
        end
        if (par_en) frame[nbits] = par_bit;
        frame_len = nbits + CNT_W'(par_en);
    end
endmodule

// File: rtl/ctx_shifter.sv
// Shifts a frame out one bit per strobe; reports when a new frame may begin.
// Assumes: start is raised only while slot is high; abort wins over all else.
module ctx_shifter #(
    parameter int FRAME_W = 9,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               abort,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   frame_len,
    output logic               txd,
    output logic               busy,
    output logic               slot
);
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   remaining;

    // A frame may begin when idle, or on the strobe that ends the last bit.
    assign slot = bit_tick && (!busy || remaining == '0);

    // Shift register, bit counter and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd       <= 1'b1;
            busy      <= 1'b0;
            remaining <= '0;
            sh        <= '0;
        end else if (abort) begin
            txd       <= 1'b1;
            busy      <= 1'b0;
            remaining <= '0;
        end else if (start) begin
            txd       <= frame[0];
            sh        <= frame >> 1;
            remaining <= frame_len - 1'b1;
            busy      <= 1'b1;
        end else if (bit_tick && busy) begin
            if (remaining != '0) begin
                txd       <= sh[0];
                sh        <= sh >> 1;
                remaining <= remaining - 1'b1;
            end else begin
                busy <= 1'b0;
                txd  <= 1'b1;
            end
        end
    end

    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !abort) |=> $stable(txd));
    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remaining < CNT_W'(FRAME_W)));
    assert_start_in_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> slot);
endmodule

// File: rtl/ctx_serializer.sv
// Top: character serializer with programmable length, parity and enable modes.
// Assumes: cts, en_mode and bit_tick are synchronous to clk; bit_tick is a
// single-cycle pulse.
module ctx_serializer
    import ctx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_ready,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              par_en,
    input  logic [1:0]        par_sel,
    input  logic [1:0]        en_mode,
    input  logic              cts,
    input  logic              bit_tick,
    output logic              txd,
    output logic              tx_idle
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    en_mode_e           mode;
    par_kind_e          pkind;
    logic               go, abort, load_ok, start, slot, busy;
    logic               buf_valid;
    logic [DATA_W-1:0]  buf_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_len;

    assign mode  = en_mode_e'(en_mode);
    assign pkind = par_kind_e'(par_sel);

    // Mode decode: which modes may begin a character, and which abort.
    always_comb begin
        go    = (mode == EN_RUN) || ((mode == EN_CTS) && cts);
        abort = (mode == EN_HALT);
    end

    assign tx_ready = !buf_valid && !abort;
    assign load_ok  = tx_load && tx_ready;
    assign start    = slot && buf_valid && go;
    assign tx_idle  = !busy;

    ctx_holdbuf #(.DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_ok),
        .data  (tx_data),
        .take  (start),
        .flush (abort),
        .valid (buf_valid),
        .q     (buf_q)
    );

    ctx_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .data      (buf_q),
        .len_code  (len_sel),
        .par_en    (par_en),
        .par_kind  (pkind),
        .frame     (frame),
        .frame_len (frame_len)
    );

    ctx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .abort     (abort),
        .start     (start),
        .frame     (frame),
        .frame_len (frame_len),
        .txd       (txd),
        .busy      (busy),
        .slot      (slot)
    );

    assert_idle_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);
    assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EN_HALT) |=> (tx_idle && txd));
    assert_cts_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == EN_CTS) |-> cts);
    assert_drain_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EN_DRAIN) |-> !start);
endmodule

// File: tb/test_ctx_serializer.sv
module test_ctx_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       tx_ready;
    logic [2:0] len_sel = '0;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = '0;
    logic [1:0] en_mode = 2'b10;
    logic       cts = 1'b0;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       tx_idle;

    int n_checks = 0;
    int n_fail = 0;
    int r5_viol = 0;
    int gap_seen = 0;
    logic exp_q[$];

    always #10 clk = ~clk;

    ctx_serializer i_ctx_serializer (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_load(tx_load),
        .tx_ready(tx_ready), .len_sel(len_sel), .par_en(par_en),
        .par_sel(par_sel), .en_mode(en_mode), .cts(cts), .bit_tick(bit_tick),
        .txd(txd), .tx_idle(tx_idle)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bit-rate strobe: one cycle high in every four.
    initial begin
        forever begin
            repeat (3) begin @(negedge clk); bit_tick = 1'b0; end
            @(negedge clk); bit_tick = 1'b1;
        end
    end

    // Monitor: pops expected bits after each strobe edge and compares.
    initial begin
        logic was_tick, prev_txd, exp_bit;
        logic [1:0] mode_at;
        prev_txd = 1'b1;
        forever begin
            @(posedge clk);
            was_tick = bit_tick;
            mode_at = en_mode;
            #5;
            if (rst_n) begin
                if (!was_tick && mode_at != 2'b00 && txd != prev_txd) r5_viol++;
                if (was_tick && !tx_idle) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected bit", int'(txd), -1);
                    end else begin
                        exp_bit = exp_q.pop_front();
                        chk(txd == exp_bit, "R2/R3/R4 serial bit", int'(txd), int'(exp_bit));
                    end
                end else if (was_tick && tx_idle && exp_q.size() != 0 && en_mode == 2'b10) begin
                    gap_seen++;
                end
            end
            prev_txd = txd;
        end
    end

    // Expected bits for a character under the current settings.
    task automatic push_char(input logic [7:0] d);
        int n;
        int ones;
        n = (len_sel == 3'd0) ? 8 : int'(len_sel);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(d[i]);
            ones += int'(d[i]);
        end
        if (par_en) begin
            case (par_sel)
                2'b00: exp_q.push_back((ones % 2) == 1);
                2'b01: exp_q.push_back((ones % 2) == 0);
                2'b10: exp_q.push_back(1'b0);
                default: exp_q.push_back(1'b1);
            endcase
        end
    endtask

    task automatic send(input logic [7:0] d);
        while (!tx_ready) @(negedge clk);
        tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        push_char(d);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0 || !tx_idle) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk(tx_idle == 1'b1, "R1 tx_idle", int'(tx_idle), 1);
        chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);

        // R6/R11: back-to-back 8-bit characters, full-buffer load ignored
        send(8'hA5);
        send(8'h3C);
        chk(tx_ready == 1'b0, "R11 ready low when full", int'(tx_ready), 0);
        tx_data = 8'hFF; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        wait_drain();
        chk(gap_seen == 0, "R6 no idle gap", gap_seen, 0);
        chk(txd == 1'b1 && tx_idle, "R10 idle mark", int'(txd), 1);

        // R2/R3: every length, even parity on and off
        for (int l = 0; l < 8; l++) begin
            len_sel = 3'(l);
            par_en = l[0];
            par_sel = 2'b00;
            send(8'h6B ^ 8'(l * 37));
            wait_drain();
            chk(exp_q.size() == 0, "R2 length drained", exp_q.size(), 0);
        end

        // R4: all parity kinds on two data patterns
        par_en = 1'b1;
        len_sel = 3'd7;
        for (int k = 0; k < 4; k++) begin
            par_sel = 2'(k);
            send(8'h55);
            send(8'h13);
            wait_drain();
            chk(exp_q.size() == 0, "R4 parity kind", k, k);
        end

        // R7: CTS gating
        len_sel = 3'd0; par_en = 1'b0;
        en_mode = 2'b11; cts = 1'b0;
        send(8'h96);
        repeat (40) @(negedge clk);
        chk(tx_idle == 1'b1, "R7 held without cts", int'(tx_idle), 1);
        chk(exp_q.size() == 8, "R7 nothing sent", exp_q.size(), 8);
        cts = 1'b1;
        while (tx_idle) @(negedge clk);
        cts = 1'b0;
        wait_drain();
        chk(exp_q.size() == 0, "R7 completes after cts drop", exp_q.size(), 0);

        // R8: drain mode
        en_mode = 2'b10; par_en = 1'b1; par_sel = 2'b01;
        send(8'h11);
        while (tx_idle) @(negedge clk);
        send(8'h22);
        en_mode = 2'b01;
        while (!tx_idle) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(tx_idle == 1'b1, "R8 no new start", int'(tx_idle), 1);
        chk(tx_ready == 1'b0, "R8 char held", int'(tx_ready), 0);
        chk(exp_q.size() == 9, "R8 first complete", exp_q.size(), 9);
        en_mode = 2'b10;
        wait_drain();
        chk(exp_q.size() == 0, "R8 held char sent", exp_q.size(), 0);

        // R9: halt mid-character
        par_en = 1'b0;
        send(8'h00);
        while (tx_idle) @(negedge clk);
        repeat (6) @(negedge clk);
        send(8'h7E);
        en_mode = 2'b00;
        @(negedge clk);
        chk(txd == 1'b1, "R9 txd mark", int'(txd), 1);
        chk(tx_idle == 1'b1, "R9 idle", int'(tx_idle), 1);
        chk(tx_ready == 1'b0, "R9 ready low", int'(tx_ready), 0);
        exp_q.delete();
        tx_data = 8'h0F; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        en_mode = 2'b10;
        repeat (60) @(negedge clk);
        chk(tx_idle == 1'b1, "R9 buffer flushed, load ignored", int'(tx_idle), 1);
        chk(tx_ready == 1'b1, "R11 ready after halt", int'(tx_ready), 1);
        chk(txd == 1'b1, "R10 idle mark", int'(txd), 1);

        chk(r5_viol == 0, "R5 bits change only on strobe", r5_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule